// File: doc/BRIEF.md
# Serial EEPROM Byte Writer with Completion Polling

This block is a two-wire bus master that stores one byte into a serial EEPROM and then finds out when the memory has finished programming it. A one-cycle `start` pulse captures a 3-bit chip select, a 16-bit word address and a data byte. The block then shifts out a complete write command. After that it keeps probing the device until the device answers, and only then reports completion.

The memory ignores the bus for as long as its internal programming cycle runs. That cycle begins at the Stop that ends the write command. Probing therefore starts straight after that Stop, with no fixed delay. Each probe is a Start followed by the device's control byte with the direction bit set for writing. A silent ninth clock means the device is still busy. The block then closes the bus with a Stop and probes again, up to a parameterised number of attempts.

The bus pins are open-drain: each output asks for its line to be pulled low, and the data line is read back through `sda_in`. One SCL period lasts `CLK_DIV` system clocks, split into four equal quarters.

Top module: `eeprom_wpoll`

## Requirements
- R1: During and after reset, `busy`, `done` and `err` are low and neither bus line is pulled. The bus stays released whenever `busy` is low.
- R2: A write command is made of these steps, in order:
  - a Start;
  - the control byte `1010`, then `chip_sel[2:0]`, then a 0 direction bit;
  - the high byte of `word_addr`, then its low byte, then `wdata`;
  - a Stop.
  Every byte goes out most significant bit first and is followed by a ninth clock on which the device must pull SDA low.
- R3: SDA changes only while SCL is low, with two exceptions: a Start, where SDA falls while SCL is high, and a Stop, where SDA rises while SCL is high. Neither occurs in the middle of a byte.
- R4: If the device leaves SDA high on any ninth clock of the write command, the block sends a Stop, sets `err`, returns to idle and does no polling. `done` stays low.
- R5: Immediately after the Stop of a successful write command, the block sends a poll: a Start, then the same control byte with direction bit 0, and no further bytes.
- R6: When a poll's ninth clock finds SDA high, the block sends a Stop and then a new poll.
- R7: When a poll's ninth clock finds SDA low, the block sends a Stop. It then raises `done` for exactly one clock, and `busy` falls in that same clock.
- R8: After `MAX_POLLS` polls have all found SDA high, the block sends a Stop, sets `err`, goes idle and never raises `done`.
- R9: A `start` pulse while idle raises `busy` on the next clock and clears `err`. A `start` pulse while busy has no effect on the bus traffic or on the result. `err` holds its value while the block is idle.
- R10: Each data and acknowledge clock holds SCL high for exactly `CLK_DIV/2` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a write |
| chip_sel | input | 3 | Device select bits placed in the control byte |
| word_addr | input | 16 | Memory address to write |
| wdata | input | 8 | Byte to store |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when the device answers a poll |
| err | output | 1 | Set by a refused write or an exhausted poll budget |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
The hardest condition to reach is a device that stays silent through many polls: either just short of the poll budget, or past it, so that the timeout branch and the retry Stop both run. The bench contains a behavioural memory model that decodes Start, Stop and the bits of each byte from the pin activity. After a completed write it stays deaf for a configured number of polls, which lets one test exhaust the poll budget and another finish after a chosen number of retries. A refused write is produced by giving the model a different chip select, or by having it refuse one chosen byte.

// File: rtl/ewp_pkg.sv
package ewp_pkg;

    localparam int CS_W = 3;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [1:0] {OP_START, OP_STOP, OP_BIT} op_e;

    typedef enum logic [2:0] {S_IDLE, S_START, S_BITS, S_ACK, S_STOP} st_e;

    typedef enum logic [2:0] {K_TO_POLL, K_RETRY, K_OK, K_FAIL, K_TMO} kind_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } pins_t;

    function automatic logic [7:0] ctrl_byte(input logic [CS_W-1:0] cs);
        return {DEV_TYPE, cs, 1'b0};
    endfunction

    function automatic logic [7:0] pick_byte(input logic [1:0] idx, input logic [CS_W-1:0] cs,
                                             input logic [15:0] addr, input logic [7:0] data);
        case (idx)
            2'd0:    return ctrl_byte(cs);
            2'd1:    return addr[15:8];
            2'd2:    return addr[7:0];
            default: return data;
        endcase
    endfunction

    // Pin levels on entry to quarter ph of an operation.
    function automatic pins_t step_pins(input op_e op, input logic [1:0] ph,
                                        input logic bitv, input pins_t cur);
        pins_t nx;
        nx = cur;
        case (op)
            OP_START: case (ph)
                2'd0: nx.sda_low = 1'b0;
                2'd1: nx.scl_low = 1'b0;
                2'd2: nx.sda_low = 1'b1;
                default: nx.scl_low = 1'b1;
            endcase
            OP_STOP: case (ph)
                2'd0: nx.sda_low = 1'b1;
                2'd1: nx.scl_low = 1'b0;
                2'd2: nx.sda_low = 1'b0;
                default: nx = cur;
            endcase
            OP_BIT: case (ph)
                2'd0: nx.sda_low = ~bitv;
                2'd1: nx.scl_low = 1'b0;
                2'd2: nx = cur;
                default: nx.scl_low = 1'b1;
            endcase
            default: nx = cur;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/ewp_qtimer.sv
module ewp_qtimer #(
    parameter int QLEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (QLEN > 1) ? $clog2(QLEN) : 1;

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(QLEN - 1));

    always_ff @(posedge clk) begin
        if (rst || !en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ewp_bitphy.sv
module ewp_bitphy
    import ewp_pkg::*;
#(
    parameter int QLEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  op_e  op,
    input  logic bitv,
    input  logic sda_in,
    output logic done,
    output logic rx,
    output logic scl_pull,
    output logic sda_pull
);
    logic       active;
    logic [1:0] ph;
    logic       tick;
    op_e        op_q;
    logic       bit_q;
    pins_t      pins;

    ewp_qtimer #(.QLEN(QLEN)) u_qt (
        .clk (clk),
        .rst (rst),
        .en  (active),
        .tick(tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            ph     <= 2'd0;
            op_q   <= OP_STOP;
            bit_q  <= 1'b1;
            pins   <= '0;
            done   <= 1'b0;
            rx     <= 1'b1;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active <= 1'b1;
                    ph     <= 2'd0;
                    op_q   <= op;
                    bit_q  <= bitv;
                    pins   <= step_pins(op, 2'd0, bitv, pins);
                end
            end else if (tick) begin
                if (ph == 2'd3) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    ph   <= ph + 2'd1;
                    pins <= step_pins(op_q, ph + 2'd1, bit_q, pins);
                    if (ph == 2'd1) begin
                        rx <= sda_in;
                    end
                end
            end
        end
    end

    assign scl_pull = pins.scl_low;
    assign sda_pull = pins.sda_low;
endmodule

// File: rtl/ewp_seq.sv
module ewp_seq
    import ewp_pkg::*;
#(
    parameter int MAX_POLLS = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [CS_W-1:0] cs,
    input  logic [15:0]     addr,
    input  logic [7:0]      data,
    input  logic            eng_done,
    input  logic            eng_rx,
    output logic            go,
    output op_e             op,
    output logic            bitv,
    output logic            busy,
    output logic            done,
    output logic            err
);
    localparam int PW = $clog2(MAX_POLLS + 1);

    st_e             st;
    kind_e           kind;
    logic [7:0]      shreg;
    logic [2:0]      bitn;
    logic [1:0]      byte_idx;
    logic            polling;
    logic [PW-1:0]   attempts;
    logic [CS_W-1:0] cs_q;
    logic [15:0]     addr_q;
    logic [7:0]      data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            kind     <= K_OK;
            shreg    <= '0;
            bitn     <= '0;
            byte_idx <= '0;
            polling  <= 1'b0;
            attempts <= '0;
            cs_q     <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            go       <= 1'b0;
            op       <= OP_STOP;
            bitv     <= 1'b1;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            go   <= 1'b0;
            done <= 1'b0;
            if (st == S_IDLE) begin
                if (start) begin
                    cs_q     <= cs;
                    addr_q   <= addr;
                    data_q   <= data;
                    err      <= 1'b0;
                    polling  <= 1'b0;
                    attempts <= '0;
                    byte_idx <= 2'd0;
                    go       <= 1'b1;
                    op       <= OP_START;
                    st       <= S_START;
                end
            end else if (eng_done) begin
                case (st)
                    S_START: begin
                        bitv  <= ctrl_byte(cs_q)[7];
                        shreg <= {ctrl_byte(cs_q)[6:0], 1'b0};
                        bitn  <= 3'd0;
                        go    <= 1'b1;
                        op    <= OP_BIT;
                        st    <= S_BITS;
                    end
                    S_BITS: begin
                        go <= 1'b1;
                        op <= OP_BIT;
                        if (bitn == 3'd7) begin
                            bitv <= 1'b1;
                            st   <= S_ACK;
                        end else begin
                            bitv  <= shreg[7];
                            shreg <= {shreg[6:0], 1'b0};
                            bitn  <= bitn + 3'd1;
                        end
                    end
                    S_ACK: begin
                        go <= 1'b1;
                        if (polling) begin
                            op <= OP_STOP;
                            st <= S_STOP;
                            if (!eng_rx) begin
                                kind <= K_OK;
                            end else if (attempts == PW'(MAX_POLLS - 1)) begin
                                kind <= K_TMO;
                            end else begin
                                attempts <= attempts + 1'b1;
                                kind     <= K_RETRY;
                            end
                        end else if (eng_rx) begin
                            kind <= K_FAIL;
                            op   <= OP_STOP;
                            st   <= S_STOP;
                        end else if (byte_idx == 2'd3) begin
                            kind <= K_TO_POLL;
                            op   <= OP_STOP;
                            st   <= S_STOP;
                        end else begin
                            byte_idx <= byte_idx + 2'd1;
                            bitv  <= pick_byte(byte_idx + 2'd1, cs_q, addr_q, data_q)[7];
                            shreg <= {pick_byte(byte_idx + 2'd1, cs_q, addr_q, data_q)[6:0], 1'b0};
                            bitn  <= 3'd0;
                            op    <= OP_BIT;
                            st    <= S_BITS;
                        end
                    end
                    S_STOP: begin
                        case (kind)
                            K_TO_POLL, K_RETRY: begin
                                polling <= 1'b1;
                                go      <= 1'b1;
                                op      <= OP_START;
                                st      <= S_START;
                            end
                            K_OK: begin
                                done <= 1'b1;
                                st   <= S_IDLE;
                            end
                            default: begin
                                err <= 1'b1;
                                st  <= S_IDLE;
                            end
                        endcase
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    assign busy = (st != S_IDLE);
endmodule

// File: rtl/eeprom_wpoll.sv
module eeprom_wpoll
    import ewp_pkg::*;
#(
    parameter int CLK_DIV   = 500,
    parameter int MAX_POLLS = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [2:0]  chip_sel,
    input  logic [15:0] word_addr,
    input  logic [7:0]  wdata,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic        scl_pull,
    output logic        sda_pull,
    input  logic        sda_in
);
    localparam int QLEN = (CLK_DIV >= 8) ? CLK_DIV / 4 : 2;

    logic go, bitv, eng_done, eng_rx;
    op_e  op;

    ewp_seq #(.MAX_POLLS(MAX_POLLS)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cs      (chip_sel),
        .addr    (word_addr),
        .data    (wdata),
        .eng_done(eng_done),
        .eng_rx  (eng_rx),
        .go      (go),
        .op      (op),
        .bitv    (bitv),
        .busy    (busy),
        .done    (done),
        .err     (err)
    );

    ewp_bitphy #(.QLEN(QLEN)) u_phy (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .op      (op),
        .bitv    (bitv),
        .sda_in  (sda_in),
        .done    (eng_done),
        .rx      (eng_rx),
        .scl_pull(scl_pull),
        .sda_pull(sda_pull)
    );
endmodule

// File: rtl/ewp_chk.sv
module ewp_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic err,
    input logic scl_pull,
    input logic sda_pull
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!busy && !done && !err && !scl_pull && !sda_pull));

    // R1
    idle_bus_free_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!scl_pull && !sda_pull));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(err));
endmodule

bind eeprom_wpoll ewp_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .scl_pull(scl_pull),
    .sda_pull(sda_pull)
);

// File: tb/sim_eeprom_wpoll.sv
module sim_eeprom_wpoll;
    localparam int CLK_DIV = 8;
    localparam int MAXP    = 6;
    localparam int HALF    = CLK_DIV / 2;

    typedef logic [7:0] bq_t[$];

    logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [2:0]  cs = '0;
    logic [15:0] addr = '0;
    logic [7:0]  data = '0;
    logic        busy, done, err, scl_pull, sda_pull;
    logic        slv_pull = 1'b0;
    logic        sda_in;

    assign sda_in = !(sda_pull || slv_pull);

    eeprom_wpoll #(.CLK_DIV(CLK_DIV), .MAX_POLLS(MAXP)) u0 (
        .clk(clk), .rst(rst), .start(start), .chip_sel(cs), .word_addr(addr),
        .wdata(data), .busy(busy), .done(done), .err(err),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .sda_in(sda_in)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    // memory model state
    logic [2:0] s_cs = '0;
    int  s_nack_idx = -1, s_nack_polls = 0, polls_left = 0;
    bit  s_busy = 0, wr_ok = 0, in_frame = 0, data_hi = 0, done_prev = 0;
    logic prev_scl = 1'b1, prev_sda = 1'b1;
    int  bitcnt = 0, bif = 0, hi_cnt = 0, n_frames = 0, done_cnt = 0;
    logic [7:0] cur = '0;
    logic [7:0] log_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bq_t mk(input logic [2:0] c, input logic [15:0] a, input logic [7:0] d,
                               input int nw, input int np);
        bq_t q;
        logic [7:0] full[4];
        full[0] = {4'b1010, c, 1'b0};
        full[1] = a[15:8];
        full[2] = a[7:0];
        full[3] = d;
        for (int i = 0; i < nw; i++) q.push_back(full[i]);
        for (int i = 0; i < np; i++) q.push_back(full[0]);
        return q;
    endfunction

    // Behavioural memory and per-clock model
    always @(negedge clk) begin : mon
        logic scl_l, sda_l;
        bit a;
        scl_l = !scl_pull;
        sda_l = sda_in;
        if (!rst) begin
            if (done) chk(!busy, "R7 busy low with done", busy, 0);
            if (done && done_prev) chk(0, "R7 done width", 2, 1);
            if (done) done_cnt++;
            if (!busy) chk(!scl_pull && !sda_pull, "R1 idle bus released",
                           {scl_pull, sda_pull}, 0);
        end
        done_prev = done;
        if (prev_scl && scl_l && prev_sda && !sda_l) begin
            chk(bitcnt == 0, "R3 start inside byte", bitcnt, 0);
            in_frame = 1; bitcnt = 0; bif = 0; wr_ok = 1;
        end else if (prev_scl && scl_l && !prev_sda && sda_l) begin
            chk(bitcnt <= 1, "R3 stop inside byte", bitcnt, 1);
            if (in_frame) begin
                n_frames++;
                if (!s_busy && bif == 4 && wr_ok) begin
                    s_busy = 1; polls_left = s_nack_polls;
                end
            end
            in_frame = 0; bitcnt = 0; data_hi = 0;
        end else if (!prev_scl && scl_l && in_frame) begin
            data_hi = 1; hi_cnt = 1;
            if (bitcnt < 8) cur = {cur[6:0], sda_l};
            bitcnt++;
        end else if (prev_scl && !scl_l && in_frame) begin
            if (data_hi) chk(hi_cnt == HALF, "R10 SCL high time", hi_cnt, HALF);
            data_hi = 0;
            if (bitcnt == 8) begin
                log_q.push_back(cur);
                if (bif == 0) begin
                    a = (cur[7:1] == {4'b1010, s_cs}) && !cur[0];
                    if (s_busy) begin
                        if (polls_left > 0) begin polls_left--; a = 0; end
                        else if (a) s_busy = 0;
                    end
                end else begin
                    a = (bif != s_nack_idx);
                end
                if (!a) wr_ok = 0;
                slv_pull = a;
            end else if (bitcnt == 9) begin
                slv_pull = 0; bitcnt = 0; bif++;
            end
        end else if (prev_scl && scl_l && data_hi) begin
            hi_cnt++;
        end
        prev_scl = scl_l;
        prev_sda = sda_l;
    end

    task automatic run_op(input logic [2:0] c, input logic [15:0] a, input logic [7:0] d,
                          input logic [2:0] scs, input int nidx, input int npolls, input bit poke);
        int n;
        s_cs = scs; s_nack_idx = nidx; s_nack_polls = npolls;
        s_busy = 0; polls_left = 0; log_q.delete(); n_frames = 0; done_cnt = 0;
        @(negedge clk);
        cs = c; addr = a; data = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", busy, 1);
        n = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
            if (poke && n == 100) begin
                cs = ~c; addr = ~a; data = ~d; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        if (n >= 20000) chk(0, "watchdog R2 operation hung", n, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic cmp_log(input bq_t e, input string tag);
        chk(log_q.size() == e.size(), {tag, " byte count"}, log_q.size(), e.size());
        for (int i = 0; i < e.size() && i < log_q.size(); i++) begin
            if (log_q[i] != e[i]) begin
                chk(0, {tag, " byte value"}, log_q[i], e[i]);
                return;
            end
        end
        chk(1, tag, 0, 0);
    endtask

    task automatic report;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (190000) @(negedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(busy == 0 && done == 0 && err == 0, "R1 flags in reset", {busy, done, err}, 0);
        chk(scl_pull == 0 && sda_pull == 0, "R1 bus in reset", {scl_pull, sda_pull}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 0 && scl_pull == 0 && sda_pull == 0, "R1 after reset", busy, 0);

        // R2 R5 R7: device answers the first poll
        run_op(3'd5, 16'h1234, 8'h5A, 3'd5, -1, 0, 0);
        cmp_log(mk(3'd5, 16'h1234, 8'h5A, 4, 1), "R2 R5 immediate answer");
        chk(n_frames == 2, "R5 frame count", n_frames, 2);
        chk(done_cnt == 1, "R7 done pulses", done_cnt, 1);
        chk(err == 0, "R7 no error", err, 0);

        // R6: three silent polls before the answer
        run_op(3'd0, 16'hFF00, 8'hC3, 3'd0, -1, 3, 0);
        cmp_log(mk(3'd0, 16'hFF00, 8'hC3, 4, 4), "R6 retried polls");
        chk(n_frames == 5, "R6 frame count", n_frames, 5);
        chk(done_cnt == 1, "R6 done pulses", done_cnt, 1);

        // R4: control byte refused (wrong chip select)
        run_op(3'd2, 16'h0001, 8'h11, 3'd6, -1, 0, 0);
        cmp_log(mk(3'd2, 16'h0001, 8'h11, 1, 0), "R4 refused control byte");
        chk(n_frames == 1, "R4 frame count", n_frames, 1);
        chk(err == 1, "R4 error set", err, 1);
        chk(done_cnt == 0, "R4 no done", done_cnt, 0);
        repeat (20) @(negedge clk);
        chk(err == 1, "R9 error held while idle", err, 1);

        // R9: new start clears the error
        run_op(3'd6, 16'hABCD, 8'h7E, 3'd6, -1, 1, 0);
        chk(err == 0, "R9 error cleared", err, 0);
        chk(done_cnt == 1, "R9 done after clear", done_cnt, 1);
        cmp_log(mk(3'd6, 16'hABCD, 8'h7E, 4, 2), "R2 one retry");

        // R4: data byte refused
        run_op(3'd1, 16'h8001, 8'h99, 3'd1, 3, 0, 0);
        cmp_log(mk(3'd1, 16'h8001, 8'h99, 4, 0), "R4 refused data byte");
        chk(err == 1, "R4 error after data", err, 1);
        chk(n_frames == 1, "R4 no polling", n_frames, 1);

        // R8: poll budget exhausted
        run_op(3'd3, 16'h4242, 8'h24, 3'd3, -1, MAXP + 5, 0);
        cmp_log(mk(3'd3, 16'h4242, 8'h24, 4, MAXP), "R8 poll limit");
        chk(n_frames == 1 + MAXP, "R8 frame count", n_frames, 1 + MAXP);
        chk(err == 1, "R8 timeout error", err, 1);
        chk(done_cnt == 0, "R8 no done", done_cnt, 0);

        // R9: start while busy is ignored
        run_op(3'd4, 16'h0F0F, 8'hA5, 3'd4, -1, 2, 1);
        cmp_log(mk(3'd4, 16'h0F0F, 8'hA5, 4, 3), "R9 busy start ignored");
        chk(done_cnt == 1 && err == 0, "R9 result unchanged", done_cnt, 1);
        repeat (60) @(negedge clk);
        chk(busy == 0, "R9 stays idle", busy, 0);
        chk(n_frames == 4, "R9 no extra traffic", n_frames, 4);

        report();
        $finish;
    end
endmodule